// File: doc/BRIEF.md
# Video clamp and gain control loop

This block is the digital half of the level control loop for one video ADC channel. It takes the digitised samples together with three timing windows: the horizontal clamp pulse, the horizontal sync pulse and vertical blanking. From these it produces clamp commands and a 9-bit gain code. The analogue clamp and the programmable amplifier obey those commands and are not part of this block.

During the clamp pulse, each sample is compared with the black-level target. The target is code 60 for a luminance channel and code 128 for a chrominance channel. The block then asks the clamp to raise or lower the level, or to hold it. Gain is corrected in two ways. The slow path works on sync. The deepest sample of each sync window is recorded, these minima are averaged over eight lines, and the gain moves by one step toward a sync-bottom target of code 1, with a dead band of one code. The fast path acts on overload. An active-video sample at or above the white-peak code 254 cuts the gain by four at once. While vertical blanking is asserted, nothing is updated.

Top module: `vclamp_gain_ctrl`

## Requirements
- R1: After synchronous reset, gain_o is 256, clamp_off_o is 1 and clamp_up_o and clamp_dn_o are 0.
- R2: One clock edge after a cycle with clamp_win_i low or vblank_i high, clamp_off_o is 1 and clamp_up_o and clamp_dn_o are 0.
- R3: With chroma_sel_i low, a valid sample inside the clamp window and outside blanking gives, one edge later, clamp_off_o = 0 and one of three results. A sample below 60 sets clamp_up_o, a sample above 60 sets clamp_dn_o, and a sample equal to 60 sets neither.
- R4: With chroma_sel_i high, the clamp target is 128, with the same up, down and hold rule.
- R5: A valid sample of 254 or more, taken outside both windows and outside blanking, lowers gain_o by 4 on the next edge. A sample of 253 leaves gain_o unchanged.
- R6: The minimum valid sample of each sync window counts as one line. After the eighth counted line, the average is taken as floor(sum/8). If the average exceeds 2, gain_o rises by 1 two edges after the first cycle with sync_win_i low. An average of 0 to 2 leaves gain_o unchanged.
- R7: While vblank_i is high, gain_o does not change, overload samples are ignored, sync samples are not recorded, and a line that closes during blanking is not counted.
- R8: gain_o saturates. A fast reduction below 0 gives 0, and a slow increase at 511 keeps it at 511.
- R9: If an overload sample arrives in the cycle when a slow update is due, only the fast reduction is applied and the slow update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 8 | Digitised video sample |
| smp_vld_i | input | 1 | Sample valid |
| clamp_win_i | input | 1 | Horizontal clamp pulse |
| sync_win_i | input | 1 | Horizontal sync pulse window |
| vblank_i | input | 1 | Vertical blanking, freezes all updates |
| chroma_sel_i | input | 1 | 1 selects the chrominance clamp target |
| clamp_up_o | output | 1 | Raise the clamp level |
| clamp_dn_o | output | 1 | Lower the clamp level |
| clamp_off_o | output | 1 | Clamp not active |
| gain_o | output | 9 | Gain code |

## Verification
The clamp comparator is tested with luminance and chrominance samples below, equal to and above each target. It is also tested inside and outside the clamp pulse and under blanking, which separates a wrong target from a wrong window gate. The sync path is driven with batches of line minima chosen so that the average falls just inside the dead band (2), just outside it (3) and well outside it (10). Some batches also include lines that close during blanking, to show whether those lines are wrongly counted. Overload samples at 253, 254 and 255 check the white-peak threshold. Long runs of overloads and of slow updates drive the gain to both saturation points. One overload placed in the update cycle checks the fast-over-slow priority.

// File: rtl/vcg_pkg.sv
package vcg_pkg;
  typedef struct packed {
    logic up;
    logic dn;
    logic off;
  } clamp_cmd_t;

  localparam clamp_cmd_t CMD_IDLE = '{up: 1'b0, dn: 1'b0, off: 1'b1};
endpackage

// File: rtl/vcg_clamp_cmp.sv
module vcg_clamp_cmp
  import vcg_pkg::*;
#(
  parameter int DW         = 8,
  parameter int LUMA_TGT   = 60,
  parameter int CHROMA_TGT = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] smp,
  input  logic          vld,
  input  logic          win,
  input  logic          vblank,
  input  logic          chroma_sel,
  output clamp_cmd_t    cmd
);
  localparam logic [DW-1:0] L_TGT = DW'(LUMA_TGT);
  localparam logic [DW-1:0] C_TGT = DW'(CHROMA_TGT);

  logic [DW-1:0] tgt;
  logic          active;

  assign tgt    = chroma_sel ? C_TGT : L_TGT;
  assign active = win & ~vblank;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= CMD_IDLE;
    end else begin
      cmd.off <= ~active;
      cmd.up  <= active & vld & (smp < tgt);
      cmd.dn  <= active & vld & (smp > tgt);
    end
  end
endmodule

// File: rtl/vcg_sync_avg.sv
module vcg_sync_avg #(
  parameter int DW         = 8,
  parameter int LINES_LOG2 = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] smp,
  input  logic          vld,
  input  logic          win,
  input  logic          vblank,
  output logic          upd,
  output logic [DW-1:0] avg
);
  localparam int SW = DW + LINES_LOG2;
  localparam logic [LINES_LOG2-1:0] LAST = {LINES_LOG2{1'b1}};

  logic                  win_d;
  logic                  seen;
  logic [DW-1:0]         line_min;
  logic [SW-1:0]         sum;
  logic [SW-1:0]         sum_nxt;
  logic [LINES_LOG2-1:0] cnt;
  logic                  close;

  assign close   = win_d & ~win;
  assign sum_nxt = sum + SW'(line_min);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_d    <= 1'b0;
      seen     <= 1'b0;
      line_min <= '1;
      sum      <= '0;
      cnt      <= '0;
      upd      <= 1'b0;
      avg      <= '0;
    end else begin
      win_d <= win;
      upd   <= 1'b0;
      if (win && vld && !vblank) begin
        seen <= 1'b1;
        if (smp < line_min) line_min <= smp;
      end
      if (close) begin
        line_min <= '1;
        seen     <= 1'b0;
        if (seen && !vblank) begin
          if (cnt == LAST) begin
            avg <= sum_nxt[SW-1:LINES_LOG2];
            upd <= 1'b1;
            sum <= '0;
            cnt <= '0;
          end else begin
            sum <= sum_nxt;
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vcg_gain_reg.sv
module vcg_gain_reg #(
  parameter int DW        = 8,
  parameter int GW        = 9,
  parameter int SYNC_TGT  = 1,
  parameter int DEADBAND  = 1,
  parameter int FAST_STEP = 4,
  parameter int GAIN_INIT = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ovl,
  input  logic          upd,
  input  logic [DW-1:0] avg,
  input  logic          vblank,
  output logic [GW-1:0] gain
);
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};
  localparam logic [GW-1:0] STEP = GW'(FAST_STEP);
  localparam logic [DW:0]   HI   = (DW+1)'(SYNC_TGT + DEADBAND);
  localparam int            LO_I = SYNC_TGT - DEADBAND;

  logic too_high;
  logic too_low;

  assign too_high = {1'b0, avg} > HI;
  generate
    if (LO_I > 0) begin : g_lo
      assign too_low = {1'b0, avg} < (DW+1)'(LO_I);
    end else begin : g_nolo
      assign too_low = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      gain <= GW'(GAIN_INIT);
    end else if (ovl) begin
      gain <= (gain >= STEP) ? gain - STEP : '0;
    end else if (upd && !vblank) begin
      if (too_high && gain != GMAX)      gain <= gain + 1'b1;
      else if (too_low && gain != '0)    gain <= gain - 1'b1;
    end
  end
endmodule

// File: rtl/vclamp_gain_ctrl.sv
module vclamp_gain_ctrl
  import vcg_pkg::*;
#(
  parameter int DW         = 8,
  parameter int GW         = 9,
  parameter int LUMA_TGT   = 60,
  parameter int CHROMA_TGT = 128,
  parameter int SYNC_TGT   = 1,
  parameter int DEADBAND   = 1,
  parameter int PEAK_LVL   = 254,
  parameter int FAST_STEP  = 4,
  parameter int LINES_LOG2 = 3,
  parameter int GAIN_INIT  = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] smp_i,
  input  logic          smp_vld_i,
  input  logic          clamp_win_i,
  input  logic          sync_win_i,
  input  logic          vblank_i,
  input  logic          chroma_sel_i,
  output logic          clamp_up_o,
  output logic          clamp_dn_o,
  output logic          clamp_off_o,
  output logic [GW-1:0] gain_o
);
  localparam logic [DW-1:0] PEAK = DW'(PEAK_LVL);

  clamp_cmd_t    cmd;
  logic          ovl;
  logic          upd;
  logic [DW-1:0] avg;

  assign ovl = smp_vld_i & (smp_i >= PEAK) & ~clamp_win_i & ~sync_win_i & ~vblank_i;

  vcg_clamp_cmp #(.DW(DW), .LUMA_TGT(LUMA_TGT), .CHROMA_TGT(CHROMA_TGT)) u_clamp (
    .clk(clk), .rst(rst), .smp(smp_i), .vld(smp_vld_i), .win(clamp_win_i),
    .vblank(vblank_i), .chroma_sel(chroma_sel_i), .cmd(cmd)
  );

  vcg_sync_avg #(.DW(DW), .LINES_LOG2(LINES_LOG2)) u_sync (
    .clk(clk), .rst(rst), .smp(smp_i), .vld(smp_vld_i), .win(sync_win_i),
    .vblank(vblank_i), .upd(upd), .avg(avg)
  );

  vcg_gain_reg #(.DW(DW), .GW(GW), .SYNC_TGT(SYNC_TGT), .DEADBAND(DEADBAND),
                 .FAST_STEP(FAST_STEP), .GAIN_INIT(GAIN_INIT)) u_gain (
    .clk(clk), .rst(rst), .ovl(ovl), .upd(upd), .avg(avg),
    .vblank(vblank_i), .gain(gain_o)
  );

  assign clamp_up_o  = cmd.up;
  assign clamp_dn_o  = cmd.dn;
  assign clamp_off_o = cmd.off;
endmodule

// File: rtl/vcg_chk.sv
module vcg_chk #(
  parameter int DW         = 8,
  parameter int GW         = 9,
  parameter int LUMA_TGT   = 60,
  parameter int CHROMA_TGT = 128,
  parameter int PEAK_LVL   = 254,
  parameter int FAST_STEP  = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] smp_i,
  input logic          smp_vld_i,
  input logic          clamp_win_i,
  input logic          sync_win_i,
  input logic          vblank_i,
  input logic          chroma_sel_i,
  input logic          clamp_up_o,
  input logic          clamp_dn_o,
  input logic          clamp_off_o,
  input logic [GW-1:0] gain_o
);
  logic [DW-1:0] ref_tgt;
  assign ref_tgt = chroma_sel_i ? DW'(CHROMA_TGT) : DW'(LUMA_TGT);

  // R2
  cmd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clamp_up_o, clamp_dn_o, clamp_off_o}));

  // R2
  idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!clamp_win_i || vblank_i) |=> clamp_off_o);

  // R3
  clamp_up_chk: assert property (@(posedge clk) disable iff (rst)
    (clamp_win_i && !vblank_i && smp_vld_i && smp_i < ref_tgt) |=> clamp_up_o);

  // R4
  clamp_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (clamp_win_i && !vblank_i && smp_vld_i && smp_i > ref_tgt) |=> clamp_dn_o);

  // R7
  blank_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    vblank_i |=> $stable(gain_o));

  // R5
  fast_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld_i && smp_i >= DW'(PEAK_LVL) && !clamp_win_i && !sync_win_i && !vblank_i)
    |=> ({1'b0, gain_o} == (($past(gain_o) >= GW'(FAST_STEP)) ?
         {1'b0, $past(gain_o)} - (GW+1)'(FAST_STEP) : '0)));

  // R8
  gain_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(gain_o) |-> ({1'b0, gain_o} == {1'b0, $past(gain_o)} + 1'b1 ||
                          {1'b0, gain_o} + 1'b1 == {1'b0, $past(gain_o)} ||
                          {1'b0, gain_o} + (GW+1)'(FAST_STEP) == {1'b0, $past(gain_o)} ||
                          gain_o == '0));
endmodule

bind vclamp_gain_ctrl vcg_chk #(
  .DW(DW), .GW(GW), .LUMA_TGT(LUMA_TGT), .CHROMA_TGT(CHROMA_TGT),
  .PEAK_LVL(PEAK_LVL), .FAST_STEP(FAST_STEP)
) u_vcg_chk (
  .clk(clk), .rst(rst), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
  .clamp_win_i(clamp_win_i), .sync_win_i(sync_win_i), .vblank_i(vblank_i),
  .chroma_sel_i(chroma_sel_i), .clamp_up_o(clamp_up_o), .clamp_dn_o(clamp_dn_o),
  .clamp_off_o(clamp_off_o), .gain_o(gain_o)
);

// File: tb/test_vclamp_gain_ctrl.sv
module test_vclamp_gain_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] smp = '0;
  logic       vld = 1'b0, cwin = 1'b0, swin = 1'b0, vb = 1'b0, csel = 1'b0;
  logic       up, dn, off;
  logic [8:0] gain;

  int total = 0, bad = 0;
  int exp_gain = 256;
  int sb_q[$];
  int line_sum = 0, line_cnt = 0;
  logic mon_en = 1'b0;
  int prev_gain = 256;
  logic done = 1'b0;

  vclamp_gain_ctrl i_vclamp_gain_ctrl (
    .clk(clk), .rst(rst), .smp_i(smp), .smp_vld_i(vld), .clamp_win_i(cwin),
    .sync_win_i(swin), .vblank_i(vb), .chroma_sel_i(csel),
    .clamp_up_o(up), .clamp_dn_o(dn), .clamp_off_o(off), .gain_o(gain)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops expected gain values whenever gain changes
  always @(negedge clk) begin
    if (mon_en && int'(gain) != prev_gain) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R6 unexpected gain change", int'(gain), prev_gain);
      end else begin
        automatic int e = sb_q.pop_front();
        chk(int'(gain) == e, "R5/R6 gain scoreboard", int'(gain), e);
      end
      prev_gain = int'(gain);
    end
  end

  task automatic push_gain(input int g);
    if (g != exp_gain) begin
      exp_gain = g;
      sb_q.push_back(g);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    vld = 1'b0; cwin = 1'b0; swin = 1'b0; smp = 8'd128;
  endtask

  // clamp sample then check one edge later
  task automatic clamp_try(input int s, input logic sel, input logic blank,
                           input logic eu, input logic ed, input logic eo, input string req);
    @(negedge clk);
    smp = 8'(s); vld = 1'b1; cwin = 1'b1; swin = 1'b0; csel = sel; vb = blank;
    @(negedge clk);
    chk(up == eu && dn == ed && off == eo, req, {up, dn, off}, {eu, ed, eo});
    cwin = 1'b0; vld = 1'b0; vb = 1'b0;
  endtask

  // one sync window with minimum m, then a close cycle
  task automatic sync_line(input int m, input logic blank);
    int vals[4];
    vals = '{m + 3, m, m + 2, m + 1};
    foreach (vals[k]) begin
      @(negedge clk);
      smp = 8'(vals[k]); vld = 1'b1; swin = 1'b1; cwin = 1'b0; vb = blank;
    end
    @(negedge clk);
    swin = 1'b0; vld = 1'b0; smp = 8'd128;
    if (!blank) begin
      line_sum += m;
      line_cnt++;
      if (line_cnt == 8) begin
        automatic int a = line_sum / 8;
        line_sum = 0; line_cnt = 0;
        if (a > 2 && exp_gain < 511) push_gain(exp_gain + 1);
      end
    end
    @(negedge clk);
    vb = 1'b0;
  endtask

  task automatic overload(input int s);
    @(negedge clk);
    smp = 8'(s); vld = 1'b1; cwin = 1'b0; swin = 1'b0; vb = 1'b0;
    if (s >= 254) push_gain(exp_gain >= 4 ? exp_gain - 4 : 0);
    @(negedge clk);
    vld = 1'b0; smp = 8'd128;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(gain == 9'd256, "R1 gain", int'(gain), 256);
    chk(off && !up && !dn, "R1 clamp idle", {up, dn, off}, 1);
    mon_en = 1'b1;

    // R3 luma target 60
    clamp_try(50, 1'b0, 1'b0, 1, 0, 0, "R3 below");
    clamp_try(70, 1'b0, 1'b0, 0, 1, 0, "R3 above");
    clamp_try(60, 1'b0, 1'b0, 0, 0, 0, "R3 equal");
    // R4 chroma target 128
    clamp_try(100, 1'b1, 1'b0, 1, 0, 0, "R4 below");
    clamp_try(128, 1'b1, 1'b0, 0, 0, 0, "R4 equal");
    clamp_try(200, 1'b1, 1'b0, 0, 1, 0, "R4 above");
    clamp_try(60, 1'b1, 1'b0, 1, 0, 0, "R4 luma code under chroma");
    // R2 blanking and outside window
    clamp_try(10, 1'b0, 1'b1, 0, 0, 1, "R2 blank");
    idle();
    @(negedge clk);
    chk(off && !up && !dn, "R2 outside window", {up, dn, off}, 1);
    csel = 1'b0;

    // R6 slow path
    for (int i = 0; i < 8; i++) sync_line(10, 1'b0);
    repeat (3) idle();
    chk(int'(gain) == exp_gain, "R6 avg 10 raises", int'(gain), exp_gain);
    for (int i = 0; i < 7; i++) sync_line(3, 1'b0);
    sync_line(0, 1'b0);
    repeat (3) idle();
    chk(int'(gain) == exp_gain, "R6 avg 2 in dead band", int'(gain), exp_gain);
    for (int i = 0; i < 8; i++) sync_line(3, 1'b0);
    repeat (3) idle();
    chk(int'(gain) == 258, "R6 avg 3 raises", int'(gain), 258);

    // R5 fast path
    overload(253);
    overload(254);
    overload(255);
    repeat (2) idle();
    chk(int'(gain) == 250, "R5 fast cuts", int'(gain), 250);

    // R7 blanking freezes
    @(negedge clk);
    smp = 8'd255; vld = 1'b1; vb = 1'b1;
    @(negedge clk);
    vld = 1'b0; vb = 1'b0;
    @(negedge clk);
    chk(int'(gain) == 250, "R7 overload ignored in blank", int'(gain), 250);
    for (int i = 0; i < 4; i++) sync_line(20, 1'b0);
    for (int i = 0; i < 4; i++) sync_line(0, 1'b1);
    for (int i = 0; i < 3; i++) sync_line(20, 1'b0);
    repeat (3) idle();
    chk(int'(gain) == 250, "R7 blank lines not counted", int'(gain), 250);
    sync_line(20, 1'b0);
    repeat (3) idle();
    chk(int'(gain) == 251, "R7 eighth counted line", int'(gain), 251);

    // R9 fast over slow in the same cycle
    for (int i = 0; i < 7; i++) sync_line(10, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      smp = 8'd10; vld = 1'b1; swin = 1'b1;
    end
    @(negedge clk);
    swin = 1'b0; smp = 8'd255; vld = 1'b1;  // close cycle; update due next edge
    line_sum = 0; line_cnt = 0;
    @(negedge clk);
    smp = 8'd255; vld = 1'b1;               // overload in update cycle
    push_gain(exp_gain - 4);
    push_gain(exp_gain - 4);
    @(negedge clk);
    vld = 1'b0; smp = 8'd128;
    repeat (2) idle();
    chk(int'(gain) == 243, "R9 fast wins", int'(gain), 243);

    // R8 low saturation
    for (int i = 0; i < 62; i++) overload(254);
    repeat (2) idle();
    chk(gain == 9'd0, "R8 floor", int'(gain), 0);
    overload(254);
    repeat (2) idle();
    chk(gain == 9'd0, "R8 stays at 0", int'(gain), 0);

    // R8 high saturation
    for (int i = 0; i < 513 * 8; i++) sync_line(10, 1'b0);
    repeat (3) idle();
    chk(gain == 9'd511, "R8 ceiling", int'(gain), 511);
    chk(sb_q.size() == 0, "R6 scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule